// File: doc/BRIEF.md
# Two-Phase Stepper Track Decoder

This block sits between a drive controller and one floppy head-stepper. The controller moves the head by walking a 2-bit phase code around a ring of four values. The block watches that code and turns each legal move into a step pulse one clock wide. Along with the pulse it gives a direction level for the drive. One instance serves one drive, and its motor-enable line gates it. While the motor is off, phase activity is discarded.

A move of one position up the ring (phase + 1, modulo 4) is an inward step with direction 0. A move of one position down the ring (phase - 1, modulo 4) is a step with direction 1. A jump to the opposite phase (phase + 2) is ambiguous, so no step is issued, but the jump is still recorded as the new reference. An optional saturating track counter follows the steps, so the controller side can see an estimate of head position.

Top module: `step_phase_decoder`

## Requirements
- R1: While rst_ni is low, and after it is released, step_o and dir_o are 0, track_o is 0 and the stored reference phase is 0.
- R2: With the motor on (motor_n_i = 0), a phase change whose value is the stored phase plus 1 modulo 4 (0 to 1, 1 to 2, 2 to 3, 3 to 0) produces one step with dir_o = 0.
- R3: With the motor on, a phase change whose value is the stored phase minus 1 modulo 4 (0 to 3, 3 to 2, 2 to 1, 1 to 0) produces one step with dir_o = 1.
- R4: With the motor on, a phase change to the stored phase plus 2 modulo 4 produces no step, but the new phase becomes the stored reference for the next change.
- R5: While motor_n_i is 1, a phase change produces no step and leaves the stored phase unchanged. Turning the motor on without a phase change produces no step.
- R6: A step pulse is exactly one clock wide. It appears on the second rising edge after the phase change is presented at phase_i.
- R7: dir_o takes the direction of a step on the same edge as step_o rises, and holds that value until the next step.
- R8: When TRACK_EN is 1, track_o increments on each direction-0 step and decrements on each direction-1 step, on the same edge as step_o.
- R9: track_o saturates: it never goes below 0 and never above TRACK_MAX.
- R10: A phase input that holds its value produces no step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 2 | Stepper phase code from the controller |
| motor_n_i | input | 1 | Motor enable for this drive, active low |
| step_o | output | 1 | Single-clock step pulse |
| dir_o | output | 1 | Step direction, 0 for the +1 ring order |
| track_o | output | TRACK_W | Saturating track position (0 when TRACK_EN = 0) |

## Verification
A wrong stored reference phase does not show at once. It shows only at the next accepted phase change: that change then appears as a missing step, an extra step or a flipped direction, two edges after the change. The bench therefore follows every transition from each starting phase, for both motor states, with a further move from the resulting state, so a corrupted reference is seen within one extra move. A counter that mistracks shows on track_o on the same edge as the step that caused the error. The clamp errors are driven out by running the counter past both ends.

// File: rtl/step_pkg.sv
package step_pkg;
  localparam int PHASE_W = 2;

  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_FWD  = 2'd1,
    MOVE_BACK = 2'd2,
    MOVE_SKIP = 2'd3
  } move_e;
endpackage

// File: rtl/phase_sampler.sv
module phase_sampler
  import step_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               motor_n_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               changed_o,
  output logic               motor_on_o
);
  logic [PHASE_W-1:0] phase_q, phase_qq;
  logic               motor_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= '0;
      phase_qq  <= '0;
      motor_n_q <= 1'b1;
    end else begin
      phase_q   <= phase_i;
      phase_qq  <= phase_q;
      motor_n_q <= motor_n_i;
    end
  end

  assign phase_o    = phase_q;
  // event only on an input change, so motor turn-on alone never steps
  assign changed_o  = (phase_q != phase_qq);
  assign motor_on_o = ~motor_n_q;
endmodule

// File: rtl/phase_decoder.sv
module phase_decoder
  import step_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               changed_i,
  input  logic               motor_on_i,
  output move_e              move_o,
  output logic               step_o,
  output logic               dir_o
);
  logic [PHASE_W-1:0] ref_q;
  logic [PHASE_W-1:0] delta;
  move_e              move;
  logic               step_q, dir_q;

  assign delta = phase_i - ref_q;

  always_comb begin
    move = MOVE_NONE;
    if (changed_i && motor_on_i) begin
      unique case (delta)
        2'd1:    move = MOVE_FWD;
        2'd3:    move = MOVE_BACK;
        2'd2:    move = MOVE_SKIP;
        default: move = MOVE_SKIP; // same as reference: no step, refresh
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      step_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      step_q <= (move == MOVE_FWD) || (move == MOVE_BACK);
      if (move != MOVE_NONE) ref_q <= phase_i;
      if (move == MOVE_FWD)  dir_q <= 1'b0;
      if (move == MOVE_BACK) dir_q <= 1'b1;
    end
  end

  assign move_o = move;
  assign step_o = step_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/track_counter.sv
module track_counter
  import step_pkg::*;
#(
  parameter int TRACK_MAX = 7,
  parameter int TRACK_W   = $clog2(TRACK_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  move_e              move_i,
  output logic [TRACK_W-1:0] track_o
);
  localparam logic [TRACK_W-1:0] MaxV = TRACK_W'(TRACK_MAX);

  logic [TRACK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (move_i == MOVE_FWD && cnt_q != MaxV) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (move_i == MOVE_BACK && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign track_o = cnt_q;
endmodule

// File: rtl/step_phase_decoder.sv
module step_phase_decoder
  import step_pkg::*;
#(
  parameter int TRACK_EN  = 1,
  parameter int TRACK_MAX = 7,
  parameter int TRACK_W   = $clog2(TRACK_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         phase_i,
  input  logic               motor_n_i,
  output logic               step_o,
  output logic               dir_o,
  output logic [TRACK_W-1:0] track_o
);
  logic [PHASE_W-1:0] phase_s;
  logic               changed_s;
  logic               motor_on_s;
  move_e              move_s;

  phase_sampler u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase_i),
    .motor_n_i  (motor_n_i),
    .phase_o    (phase_s),
    .changed_o  (changed_s),
    .motor_on_o (motor_on_s)
  );

  phase_decoder u_decoder (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase_s),
    .changed_i  (changed_s),
    .motor_on_i (motor_on_s),
    .move_o     (move_s),
    .step_o     (step_o),
    .dir_o      (dir_o)
  );

  generate
    if (TRACK_EN != 0) begin : g_track
      track_counter #(
        .TRACK_MAX (TRACK_MAX),
        .TRACK_W   (TRACK_W)
      ) u_track (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .move_i  (move_s),
        .track_o (track_o)
      );
    end else begin : g_no_track
      assign track_o = '0;
    end
  endgenerate
endmodule

// File: rtl/step_phase_decoder_chk.sv
module step_phase_decoder_chk #(
  parameter int TRACK_EN  = 1,
  parameter int TRACK_MAX = 7,
  parameter int TRACK_W   = $clog2(TRACK_MAX + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         phase_i,
  input logic               motor_n_i,
  input logic               step_o,
  input logic               dir_o,
  input logic [TRACK_W-1:0] track_o
);
  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 1'b1;
  end

  // R10
  no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && $past(phase_i, 2) == $past(phase_i, 3)) |-> !step_o);

  // R5
  motor_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && $past(motor_n_i, 2)) |-> !step_o);

  // R7
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0 && !step_o) |-> $stable(dir_o));

  // R9
  track_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    track_o <= TRACK_W'(TRACK_MAX));

  // R8
  track_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0 && !step_o) |-> $stable(track_o));

  // R8
  track_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TRACK_EN != 0 && warm_q != 2'd0 && step_o && !dir_o && $past(track_o) != TRACK_W'(TRACK_MAX))
      |-> track_o == $past(track_o) + 1'b1);

  // R8
  track_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TRACK_EN != 0 && warm_q != 2'd0 && step_o && dir_o && $past(track_o) != '0)
      |-> track_o == $past(track_o) - 1'b1);
endmodule

bind step_phase_decoder step_phase_decoder_chk #(
  .TRACK_EN  (TRACK_EN),
  .TRACK_MAX (TRACK_MAX),
  .TRACK_W   (TRACK_W)
) u_chk (.*);

// File: tb/sim_step_phase_decoder.sv
module sim_step_phase_decoder;
  localparam int TRACK_MAX = 7;
  localparam int TRACK_W   = $clog2(TRACK_MAX + 1);

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic [1:0]         phase_i;
  logic               motor_n_i;
  logic               step_o;
  logic               dir_o;
  logic [TRACK_W-1:0] track_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0] ref_m  = 2'd0;
  logic [1:0] last_m = 2'd0;
  logic       dir_m  = 1'b0;
  int         trk_m  = 0;

  always #5 clk_i = ~clk_i;

  step_phase_decoder #(.TRACK_EN(1), .TRACK_MAX(TRACK_MAX)) u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase_i),
    .motor_n_i (motor_n_i),
    .step_o    (step_o),
    .dir_o     (dir_o),
    .track_o   (track_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [1:0] ph, input logic mo);
    logic       exp_step = 1'b0;
    logic       clamped  = 1'b0;
    logic [1:0] d;
    string      tag      = "R10";
    phase_i   = ph;
    motor_n_i = mo;
    if (ph != last_m) begin
      if (mo) begin
        tag = "R5";
      end else begin
        d = ph - ref_m;
        ref_m = ph;
        if (d == 2'd1) begin
          tag = "R2"; exp_step = 1'b1; dir_m = 1'b0;
          if (trk_m == TRACK_MAX) clamped = 1'b1; else trk_m++;
        end else if (d == 2'd3) begin
          tag = "R3"; exp_step = 1'b1; dir_m = 1'b1;
          if (trk_m == 0) clamped = 1'b1; else trk_m--;
        end else begin
          tag = "R4";
        end
      end
    end
    last_m = ph;
    @(negedge clk_i);
    @(negedge clk_i);
    check(tag, int'(step_o), int'(exp_step));
    check("R7", int'(dir_o), int'(dir_m));
    check(clamped ? "R9" : "R8", int'(track_o), trk_m);
    @(negedge clk_i);
    check("R6", int'(step_o), 0);
  endtask

  initial begin
    rst_ni    = 1'b0;
    phase_i   = 2'd0;
    motor_n_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1", int'(step_o), 0);
    check("R1", int'(dir_o), 0);
    check("R1", int'(track_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", int'(step_o), 0);
    check("R1", int'(track_o), 0);

    // R1 reference is 0: first move 0->1 with motor on is forward
    apply(2'd1, 1'b0);

    // R2 R3 R4 R5: every start phase, every target, both motor states
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 4; p++)
        for (int n = 0; n < 4; n++) begin
          apply(2'(p), 1'b0);
          apply(2'(n), 1'(m));
          apply(2'(n), 1'b0);
          apply(2'(n + 1), 1'b0);
        end

    // R9 upper clamp then lower clamp
    for (int k = 0; k < TRACK_MAX + 4; k++) apply(last_m + 2'd1, 1'b0);
    for (int k = 0; k < TRACK_MAX + 4; k++) apply(last_m - 2'd1, 1'b0);

    // R10 steady input
    apply(last_m, 1'b0);
    apply(last_m, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule